// File: doc/BRIEF.md
# Pruned Exhaustive Block Matcher

This block finds the motion vector of one square block of the current picture inside a small reference search area. It tries every integer displacement from -R to +R on both axes. Its cost is the sum of absolute differences (SAD) between the current block and the displaced reference block. Before it spends a full accumulation on a candidate, it computes a cheap lower bound on that candidate's SAD. The bound is the absolute difference between the pixel total of the current block and the pixel total of the candidate reference block. If the bound is not below the smallest SAD found so far, the candidate cannot win, and the block drops it in a single cycle. The answer is therefore the same as plain exhaustive search, and fewer cycles are spent on hopeless positions.

The user first loads the current-block pixels and the search-area pixels through two write ports. The user then selects the block size with `mode` and pulses `start`. A controller walks through the states IDLE, CSUM, INTEG, BOUND, ACCUM and DONE:

- IDLE moves to CSUM on an accepted start.
- CSUM adds up the current block's pixels, one per clock, and moves to INTEG after the last pixel.
- INTEG builds a summed-area table of the search area, one pixel per clock, and moves to BOUND after the last pixel.
- BOUND tests one candidate's bound. If the candidate is pruned, it moves to the next candidate, or to DONE after the last one. Otherwise it moves to ACCUM.
- ACCUM adds one absolute difference per clock. After the block's last pixel it returns to BOUND, or moves to DONE after the last candidate.
- DONE raises `done` for one cycle and returns to IDLE.

Top module: `fs_block_matcher`

## Requirements
- R1: When `done` is high, `best_sad` equals the minimum over all candidates of the sum over block pixels (x,y), 0 <= x,y < N, of |cur(x,y) - win(x+dx+R, y+dy+R)|.
- R2: Every displacement with dx and dy in [-R, R] is a candidate, giving (2R+1)^2 candidates. `mv_x` = dx and `mv_y` = dy of the chosen candidate, in two's complement.
- R3: Candidates are visited with dy as the outer loop and dx as the inner loop, both ascending. On equal SAD, the candidate visited first is kept.
- R4: A candidate is pruned, with no accumulation, exactly when |sum of the current block - sum of the candidate block| is at least the running minimum. `skip_count` equals the number of candidates pruned.
- R5: The reported vector and SAD are identical to those of an unpruned exhaustive search with the tie rule of R3.
- R6: The running minimum starts at 2^16-1, so the first candidate is never pruned and `skip_count` never exceeds (2R+1)^2-1.
- R7: `mode` is sampled on the accepted start: 0 selects a 4x4 block, 1 selects 8x8, and 2 or 3 selects 16x16. Later changes to `mode` have no effect on that search.
- R8: Current pixel (x,y) is written at `cur_addr` = 16*y+x, and the block uses the top-left NxN of this area. Search-area pixel (x,y) is written at `win_addr` = (16+2R)*y+x.
- R9: `busy` is high from the cycle after an accepted start through the cycle in which `done` is high. `done` is a one-cycle pulse. `best_sad`, `mv_x`, `mv_y` and `skip_count` hold their values until the next start.
- R10: A `start` pulse that arrives while `busy` is high is ignored.
- R11: After reset, `busy`, `done`, `best_sad`, `mv_x`, `mv_y` and `skip_count` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cur_we | input | 1 | Current-block pixel write enable |
| cur_addr | input | 8 | Current-block pixel address, 16*y+x |
| cur_data | input | PIX_W | Current-block pixel value |
| win_we | input | 1 | Search-area pixel write enable |
| win_addr | input | 9 | Search-area pixel address, (16+2R)*y+x |
| win_data | input | PIX_W | Search-area pixel value |
| mode | input | 2 | Block size select, sampled at start |
| start | input | 1 | Begin a search, accepted only when idle |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse when the result is final |
| mv_x | output | 3 | Horizontal displacement of the best match |
| mv_y | output | 3 | Vertical displacement of the best match |
| best_sad | output | 16 | SAD of the best match |
| skip_count | output | 5 | Number of candidates pruned by the bound |

## Verification
The search is run with search areas of random texture that contain an exact copy of the current block. This shows whether the addressing and the minimum search land on the planted displacement. A flat area with a matching flat block makes every candidate tie at zero SAD. It separates the first-visited tie rule, and it prunes everything after the first candidate. Fully random data with no exact match exercise minima that are not zero, and a smooth gradient makes the bound prune heavily. In each run the pruned count and the result are compared with a reference model and with a plain exhaustive search. Directed runs cover all four mode codes, a start and a mode change in the middle of a search, and the done pulse followed by the held result.

// File: rtl/bm_pkg.sv
package bm_pkg;
    localparam int MAX_BLK = 16;
    localparam int BLK_W   = $clog2(MAX_BLK + 1);

    typedef enum logic [2:0] {
        S_IDLE,
        S_CSUM,
        S_INTEG,
        S_BOUND,
        S_ACCUM,
        S_DONE
    } bm_state_e;

    function automatic logic [BLK_W-1:0] blk_size(input logic [1:0] sel);
        logic [BLK_W-1:0] n;
        unique case (sel)
            2'd0:    n = BLK_W'(4);
            2'd1:    n = BLK_W'(8);
            default: n = BLK_W'(16);
        endcase
        return n;
    endfunction
endpackage

// File: rtl/bm_pixel_store.sv
module bm_pixel_store #(
    parameter int PIX_W   = 8,
    parameter int CUR_PIX = 256,
    parameter int WIN_PIX = 400,
    localparam int CUR_AW = $clog2(CUR_PIX),
    localparam int WIN_AW = $clog2(WIN_PIX)
) (
    input  logic              clk,
    input  logic              cur_we,
    input  logic [CUR_AW-1:0] cur_waddr,
    input  logic [PIX_W-1:0]  cur_wdata,
    input  logic              win_we,
    input  logic [WIN_AW-1:0] win_waddr,
    input  logic [PIX_W-1:0]  win_wdata,
    input  logic [CUR_AW-1:0] cur_raddr,
    input  logic [WIN_AW-1:0] win_raddr,
    output logic [PIX_W-1:0]  cur_q,
    output logic [PIX_W-1:0]  win_q
);
    logic [PIX_W-1:0] cur_mem [CUR_PIX];
    logic [PIX_W-1:0] win_mem [WIN_PIX];

    always_ff @(posedge clk) begin
        if (cur_we && (int'(cur_waddr) < CUR_PIX))
            cur_mem[cur_waddr] <= cur_wdata;
        if (win_we && (int'(win_waddr) < WIN_PIX))
            win_mem[win_waddr] <= win_wdata;
    end

    always_comb begin
        cur_q = (int'(cur_raddr) < CUR_PIX) ? cur_mem[cur_raddr] : '0;
        win_q = (int'(win_raddr) < WIN_PIX) ? win_mem[win_raddr] : '0;
    end
endmodule

// File: rtl/bm_box_sum.sv
module bm_box_sum #(
    parameter int PIX_W = 8,
    parameter int WIN   = 20,
    parameter int SUM_W = 16,
    parameter int BLK_W = 5,
    localparam int POS_W = $clog2(WIN + 1),
    localparam int TBL_N = (WIN + 1) * (WIN + 1),
    localparam int TBL_AW = $clog2(TBL_N),
    localparam int II_W = PIX_W + $clog2(WIN * WIN + 1)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [POS_W-1:0] wr_y,
    input  logic [POS_W-1:0] wr_x,
    input  logic [PIX_W-1:0] wr_pix,
    input  logic [POS_W-1:0] q_y,
    input  logic [POS_W-1:0] q_x,
    input  logic [BLK_W-1:0] q_n,
    output logic [SUM_W-1:0] box_sum
);
    // Summed-area table with an implicit zero first row and column.
    logic [II_W-1:0] tbl [TBL_N];
    logic [II_W-1:0] wr_val;
    logic [II_W-1:0] box_full;

    function automatic logic [II_W-1:0] rd(input int y, input int x);
        if (y == 0 || x == 0)
            return '0;
        return tbl[TBL_AW'(y * (WIN + 1) + x)];
    endfunction

    always_comb begin
        int wy, wx, qy, qx, qn;
        wy = int'(wr_y);
        wx = int'(wr_x);
        qy = int'(q_y);
        qx = int'(q_x);
        qn = int'(q_n);
        wr_val = II_W'(wr_pix) + rd(wy, wx + 1) + rd(wy + 1, wx) - rd(wy, wx);
        box_full = rd(qy + qn, qx + qn) - rd(qy, qx + qn) - rd(qy + qn, qx) + rd(qy, qx);
        box_sum = SUM_W'(box_full);
    end

    always_ff @(posedge clk) begin
        if (wr_en)
            tbl[TBL_AW'((int'(wr_y) + 1) * (WIN + 1) + int'(wr_x) + 1)] <= wr_val;
    end
endmodule

// File: rtl/fs_block_matcher.sv
module fs_block_matcher
    import bm_pkg::*;
#(
    parameter int PIX_W = 8,
    parameter int RANGE = 2,
    localparam int WIN     = MAX_BLK + 2 * RANGE,
    localparam int CUR_PIX = MAX_BLK * MAX_BLK,
    localparam int WIN_PIX = WIN * WIN,
    localparam int CUR_AW  = $clog2(CUR_PIX),
    localparam int WIN_AW  = $clog2(WIN_PIX),
    localparam int NSPAN   = 2 * RANGE + 1,
    localparam int NCAND   = NSPAN * NSPAN,
    localparam int SAD_W   = PIX_W + $clog2(CUR_PIX),
    localparam int CNT_W   = $clog2(NCAND + 1),
    localparam int MV_W    = $clog2(RANGE + 1) + 1,
    localparam int CO_W    = $clog2(NSPAN),
    localparam int POS_W   = $clog2(WIN + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cur_we,
    input  logic [CUR_AW-1:0]       cur_addr,
    input  logic [PIX_W-1:0]        cur_data,
    input  logic                    win_we,
    input  logic [WIN_AW-1:0]       win_addr,
    input  logic [PIX_W-1:0]        win_data,
    input  logic [1:0]              mode,
    input  logic                    start,
    output logic                    busy,
    output logic                    done,
    output logic signed [MV_W-1:0]  mv_x,
    output logic signed [MV_W-1:0]  mv_y,
    output logic [SAD_W-1:0]        best_sad,
    output logic [CNT_W-1:0]        skip_count
);
    localparam logic [POS_W-1:0] WIN_LAST  = POS_W'(WIN - 1);
    localparam logic [CO_W-1:0]  SPAN_LAST = CO_W'(NSPAN - 1);
    localparam logic [CNT_W-1:0] SKIP_MAX  = CNT_W'(NCAND - 1);

    bm_state_e state_q, state_d;

    logic [BLK_W-1:0]       size_q;
    logic [BLK_W-1:0]       px_q, py_q;
    logic [POS_W-1:0]       ix_q, iy_q;
    logic [CO_W-1:0]        cx_q, cy_q;
    logic [SAD_W-1:0]       cur_sum_q, acc_q, lb_q, best_q;
    logic signed [MV_W-1:0] mvx_q, mvy_q;
    logic [CNT_W-1:0]       skip_q;

    logic [CUR_AW-1:0] cur_raddr;
    logic [WIN_AW-1:0] win_raddr;
    logic [PIX_W-1:0]  cur_q, win_q;
    logic [SAD_W-1:0]  ref_sum, bound, pix_diff, sad_total;
    logic              last_pix, last_cand, last_integ, prune;

    bm_pixel_store #(.PIX_W(PIX_W), .CUR_PIX(CUR_PIX), .WIN_PIX(WIN_PIX)) u_store (
        .clk       (clk),
        .cur_we    (cur_we),
        .cur_waddr (cur_addr),
        .cur_wdata (cur_data),
        .win_we    (win_we),
        .win_waddr (win_addr),
        .win_wdata (win_data),
        .cur_raddr (cur_raddr),
        .win_raddr (win_raddr),
        .cur_q     (cur_q),
        .win_q     (win_q)
    );

    bm_box_sum #(.PIX_W(PIX_W), .WIN(WIN), .SUM_W(SAD_W), .BLK_W(BLK_W)) u_box (
        .clk     (clk),
        .wr_en   (state_q == S_INTEG),
        .wr_y    (iy_q),
        .wr_x    (ix_q),
        .wr_pix  (win_q),
        .q_y     (POS_W'(cy_q)),
        .q_x     (POS_W'(cx_q)),
        .q_n     (size_q),
        .box_sum (ref_sum)
    );

    // Read addressing and candidate arithmetic
    always_comb begin
        cur_raddr = CUR_AW'(int'(py_q) * MAX_BLK + int'(px_q));
        if (state_q == S_INTEG)
            win_raddr = WIN_AW'(int'(iy_q) * WIN + int'(ix_q));
        else
            win_raddr = WIN_AW'((int'(cy_q) + int'(py_q)) * WIN + int'(cx_q) + int'(px_q));
        bound      = (cur_sum_q >= ref_sum) ? cur_sum_q - ref_sum : ref_sum - cur_sum_q;
        pix_diff   = SAD_W'((cur_q >= win_q) ? cur_q - win_q : win_q - cur_q);
        sad_total  = acc_q + pix_diff;
        last_pix   = (px_q == size_q - 1'b1) && (py_q == size_q - 1'b1);
        last_cand  = (cx_q == SPAN_LAST) && (cy_q == SPAN_LAST);
        last_integ = (ix_q == WIN_LAST) && (iy_q == WIN_LAST);
        prune      = (bound >= best_q);
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (start) state_d = S_CSUM;
            S_CSUM:  if (last_pix) state_d = S_INTEG;
            S_INTEG: if (last_integ) state_d = S_BOUND;
            S_BOUND: begin
                if (!prune)         state_d = S_ACCUM;
                else if (last_cand) state_d = S_DONE;
            end
            S_ACCUM: if (last_pix) state_d = last_cand ? S_DONE : S_BOUND;
            S_DONE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // Datapath and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            size_q    <= '0;
            px_q      <= '0;
            py_q      <= '0;
            ix_q      <= '0;
            iy_q      <= '0;
            cx_q      <= '0;
            cy_q      <= '0;
            cur_sum_q <= '0;
            acc_q     <= '0;
            lb_q      <= '0;
            best_q    <= '0;
            mvx_q     <= '0;
            mvy_q     <= '0;
            skip_q    <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: if (start) begin
                    size_q    <= blk_size(mode);
                    px_q      <= '0;
                    py_q      <= '0;
                    ix_q      <= '0;
                    iy_q      <= '0;
                    cx_q      <= '0;
                    cy_q      <= '0;
                    cur_sum_q <= '0;
                    best_q    <= '1;
                    mvx_q     <= '0;
                    mvy_q     <= '0;
                    skip_q    <= '0;
                end
                S_CSUM: begin
                    cur_sum_q <= cur_sum_q + SAD_W'(cur_q);
                    if (px_q == size_q - 1'b1) begin
                        px_q <= '0;
                        py_q <= last_pix ? '0 : py_q + 1'b1;
                    end else begin
                        px_q <= px_q + 1'b1;
                    end
                end
                S_INTEG: begin
                    if (ix_q == WIN_LAST) begin
                        ix_q <= '0;
                        iy_q <= iy_q + 1'b1;
                    end else begin
                        ix_q <= ix_q + 1'b1;
                    end
                end
                S_BOUND: begin
                    lb_q <= bound;
                    if (prune) begin
                        skip_q <= skip_q + 1'b1;
                        if (cx_q == SPAN_LAST) begin
                            cx_q <= '0;
                            cy_q <= cy_q + 1'b1;
                        end else begin
                            cx_q <= cx_q + 1'b1;
                        end
                    end else begin
                        acc_q <= '0;
                        px_q  <= '0;
                        py_q  <= '0;
                    end
                end
                S_ACCUM: begin
                    acc_q <= sad_total;
                    if (px_q == size_q - 1'b1) begin
                        px_q <= '0;
                        py_q <= last_pix ? '0 : py_q + 1'b1;
                    end else begin
                        px_q <= px_q + 1'b1;
                    end
                    if (last_pix) begin
                        if (sad_total < best_q) begin
                            best_q <= sad_total;
                            mvx_q  <= MV_W'(int'(cx_q) - RANGE);
                            mvy_q  <= MV_W'(int'(cy_q) - RANGE);
                        end
                        if (cx_q == SPAN_LAST) begin
                            cx_q <= '0;
                            cy_q <= cy_q + 1'b1;
                        end else begin
                            cx_q <= cx_q + 1'b1;
                        end
                    end
                end
                S_DONE: ;
                default: ;
            endcase
        end
    end

    assign busy       = (state_q != S_IDLE);
    assign done       = (state_q == S_DONE);
    assign mv_x       = mvx_q;
    assign mv_y       = mvy_q;
    assign best_sad   = best_q;
    assign skip_count = skip_q;

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_min_not_rising_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_BOUND || state_q == S_ACCUM) |=> (best_q <= $past(best_q)));

    // The bound held since BOUND never exceeds the finished SAD.
    assert_bound_sound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ACCUM && last_pix) |-> (sad_total >= lb_q));

    assert_skip_counts_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_BOUND && prune) |=> (skip_q == $past(skip_q) + 1'b1));

    assert_first_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        skip_q <= SKIP_MAX);

    assert_size_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_IDLE && $past(state_q) != S_IDLE) |-> $stable(size_q));

    assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == S_BOUND || state_q == S_ACCUM) && start) |=> (state_q != S_CSUM));
endmodule

// File: tb/test_fs_block_matcher.sv
module test_fs_block_matcher;
    localparam int PIX_W = 8;
    localparam int RANGE = 2;
    localparam int MAXB  = 16;
    localparam int WIN   = MAXB + 2 * RANGE;
    localparam int NSPAN = 2 * RANGE + 1;
    localparam int NCAND = NSPAN * NSPAN;

    // Stimulus table: mode, pattern (0 planted random, 1 flat, 2 random, 3 planted gradient),
    // seed, planted dx/dy, and expected vector (99 = taken from the model only).
    localparam int NVEC = 8;
    localparam int T_MODE [NVEC] = '{0, 1, 2, 0, 1, 2, 3, 0};
    localparam int T_PAT  [NVEC] = '{0, 0, 0, 1, 2, 3, 2, 2};
    localparam int T_SEED [NVEC] = '{11, 23, 5, 0, 9, 0, 41, 3};
    localparam int T_DX   [NVEC] = '{1, -2, 0, 0, 0, 2, 0, 0};
    localparam int T_DY   [NVEC] = '{-2, 2, 0, 0, 0, 1, 0, 0};
    localparam int T_EX   [NVEC] = '{1, -2, 0, -2, 99, 2, 99, 99};
    localparam int T_EY   [NVEC] = '{-2, 2, 0, -2, 99, 1, 99, 99};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cur_we = 1'b0;
    logic [7:0] cur_addr = '0;
    logic [PIX_W-1:0] cur_data = '0;
    logic win_we = 1'b0;
    logic [8:0] win_addr = '0;
    logic [PIX_W-1:0] win_data = '0;
    logic [1:0] mode = '0;
    logic start = 1'b0;
    logic busy, done;
    logic signed [2:0] mv_x, mv_y;
    logic [15:0] best_sad;
    logic [4:0] skip_count;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int m_cur [MAXB*MAXB];
    int m_win [WIN*WIN];

    fs_block_matcher #(.PIX_W(PIX_W), .RANGE(RANGE)) i_fs_block_matcher (
        .clk(clk), .rst_n(rst_n),
        .cur_we(cur_we), .cur_addr(cur_addr), .cur_data(cur_data),
        .win_we(win_we), .win_addr(win_addr), .win_data(win_data),
        .mode(mode), .start(start), .busy(busy), .done(done),
        .mv_x(mv_x), .mv_y(mv_y), .best_sad(best_sad), .skip_count(skip_count)
    );

    always #5 clk = ~clk;

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 190000) begin
                n_chk++;
                n_fail++;
                $display("FAIL watchdog: actual=%0d expected<=190000 cycles", cyc);
                summary();
                $finish;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int hpix(input int seed, input int i);
        logic [31:0] h;
        h = 32'(seed) * 32'd1103515245 + 32'(i) * 32'd2654435761 + 32'd97;
        h = h ^ (h >> 15);
        h = h * 32'd2246822519;
        return int'((h >> 13) & 32'hFF);
    endfunction

    function automatic int nsize(input int m);
        return (m == 0) ? 4 : (m == 1) ? 8 : 16;
    endfunction

    task automatic fill(input int pat, input int seed, input int dx, input int dy, input int n);
        for (int y = 0; y < WIN; y++)
            for (int x = 0; x < WIN; x++)
                m_win[y*WIN+x] = (pat == 1) ? 77 : (pat == 3) ? ((x*7 + y*13) & 255) : hpix(seed, y*WIN+x);
        for (int y = 0; y < MAXB; y++)
            for (int x = 0; x < MAXB; x++) begin
                if (pat == 1) m_cur[y*MAXB+x] = 77;
                else if ((pat == 0 || pat == 3) && x < n && y < n)
                    m_cur[y*MAXB+x] = m_win[(y+dy+RANGE)*WIN + x+dx+RANGE];
                else m_cur[y*MAXB+x] = hpix(seed + 1000, y*MAXB+x);
            end
    endtask

    task automatic load();
        for (int a = 0; a < MAXB*MAXB; a++) begin
            @(negedge clk);
            cur_we = 1'b1; cur_addr = 8'(a); cur_data = PIX_W'(m_cur[a]);
        end
        for (int a = 0; a < WIN*WIN; a++) begin
            @(negedge clk);
            cur_we = 1'b0;
            win_we = 1'b1; win_addr = 9'(a); win_data = PIX_W'(m_win[a]);
        end
        @(negedge clk);
        cur_we = 1'b0; win_we = 1'b0;
    endtask

    // Reference: pruned walk (skip count) and plain exhaustive walk.
    task automatic model(input int n, output int p_sad, output int p_x, output int p_y,
                         output int p_skip, output int e_sad, output int e_x, output int e_y);
        int cs, rs, sad, lb;
        cs = 0;
        for (int y = 0; y < n; y++)
            for (int x = 0; x < n; x++) cs += m_cur[y*MAXB+x];
        p_sad = 65535; p_x = 0; p_y = 0; p_skip = 0;
        e_sad = 65535; e_x = 0; e_y = 0;
        for (int cy = 0; cy < NSPAN; cy++)
            for (int cx = 0; cx < NSPAN; cx++) begin
                rs = 0; sad = 0;
                for (int y = 0; y < n; y++)
                    for (int x = 0; x < n; x++) begin
                        int r, c;
                        r = m_win[(cy+y)*WIN + cx+x];
                        c = m_cur[y*MAXB+x];
                        rs += r;
                        sad += (c > r) ? c - r : r - c;
                    end
                lb = (cs > rs) ? cs - rs : rs - cs;
                if (sad < e_sad) begin e_sad = sad; e_x = cx - RANGE; e_y = cy - RANGE; end
                if (lb >= p_sad) p_skip++;
                else if (sad < p_sad) begin p_sad = sad; p_x = cx - RANGE; p_y = cy - RANGE; end
            end
    endtask

    task automatic kick(input int m);
        @(negedge clk);
        mode = 2'(m); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        while (done !== 1'b1) @(negedge clk);
    endtask

    initial begin
        int p_sad, p_x, p_y, p_skip, e_sad, e_x, e_y, h_sad, h_x;
        repeat (3) @(negedge clk);
        // R11: reset state
        chk(busy == 1'b0, "R11 busy", busy, 0);
        chk(done == 1'b0, "R11 done", done, 0);
        chk(best_sad == 0, "R11 best_sad", best_sad, 0);
        chk(mv_x == 0 && mv_y == 0, "R11 mv", mv_x, 0);
        chk(skip_count == 0, "R11 skip_count", skip_count, 0);
        rst_n = 1'b1;

        for (int v = 0; v < NVEC; v++) begin
            int n;
            n = nsize(T_MODE[v]);
            fill(T_PAT[v], T_SEED[v], T_DX[v], T_DY[v], n);
            load();
            model(n, p_sad, p_x, p_y, p_skip, e_sad, e_x, e_y);
            kick(T_MODE[v]);
            chk(busy == 1'b1, "R9 busy after start", busy, 1);
            wait_done();
            chk(int'(best_sad) == p_sad, "R1 best_sad", best_sad, p_sad);
            chk(int'(mv_x) == p_x, "R2 mv_x", mv_x, p_x);
            chk(int'(mv_y) == p_y, "R2 mv_y", mv_y, p_y);
            chk(int'(skip_count) == p_skip, "R4 skip_count", skip_count, p_skip);
            chk(int'(best_sad) == e_sad && int'(mv_x) == e_x && int'(mv_y) == e_y,
                "R5 equals exhaustive sad", best_sad, e_sad);
            if (T_EX[v] != 99) begin
                chk(int'(mv_x) == T_EX[v] && int'(mv_y) == T_EY[v], "R8 planted mv_x", mv_x, T_EX[v]);
                chk(best_sad == 0, "R8 planted sad", best_sad, 0);
            end
            if (T_PAT[v] == 1) begin
                chk(int'(mv_x) == -RANGE && int'(mv_y) == -RANGE, "R3 tie keeps first", mv_x, -RANGE);
                chk(int'(skip_count) == NCAND - 1, "R6 first never pruned", skip_count, NCAND - 1);
            end
            if (T_MODE[v] == 3)
                chk(int'(best_sad) == p_sad, "R7 mode 3 as 16x16", best_sad, p_sad);
        end

        // R10 and R7: start and mode change during a search have no effect.
        model(16, p_sad, p_x, p_y, p_skip, e_sad, e_x, e_y);
        kick(2);
        repeat (700) @(negedge clk);
        mode = 2'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        chk(int'(best_sad) == p_sad, "R10 restart ignored sad", best_sad, p_sad);
        chk(int'(skip_count) == p_skip, "R7 mode change ignored skip", skip_count, p_skip);
        h_sad = int'(best_sad);
        h_x = int'(mv_x);
        @(negedge clk);
        chk(done == 1'b0, "R9 done one cycle", done, 0);
        chk(busy == 1'b0, "R9 busy ends with done", busy, 0);
        repeat (5) @(negedge clk);
        chk(int'(best_sad) == h_sad && int'(mv_x) == h_x, "R9 result held", best_sad, h_sad);

        summary();
        $finish;
    end
endmodule